// File: doc/BRIEF.md
# Data Link Byte Capture Unit

This block takes a serial data link bit stream that arrives one bit per strobe, typically one bit per frame. When enabled, it removes zeros that a sender stuffed into the stream, and it packs the remaining bits into bytes, least significant bit first. Each completed byte is placed in a register that the host can read. Every completed byte is also compared with two match bytes that the host programs. A host can therefore ignore the stream until a byte it cares about appears.

Two sticky status bits report events: byte captured and pattern matched. An active-low interrupt goes low while an enabled status bit is set. The host uses a small register port with a 2-bit address. Writes set the control bits and the two match bytes. Reads return the captured byte or the status. Reading the status clears it.

Top module: `dlink_capture`

## Requirements
- R1: Bits that enter the shift register are packed least significant bit first. After 8 such bits, the byte is readable at address 0.
- R2: A completed byte sets the full status, which is bit 0 of the status word at address 3.
- R3: A byte that is not read before the next byte completes is overwritten, so the register holds the newer byte.
- R4: A completed byte equal to match byte 0 (written at address 1) or to match byte 1 (written at address 2) sets the match status, which is status bit 1. A byte that equals neither leaves that bit clear.
- R5: The interrupt output is low while full status is set with control bit 1 set, or while match status is set with control bit 2 set. With both of these control bits clear, it stays high.
- R6: When control bit 0 (destuff enable) is clear, every valid bit enters the shift register.
- R7: When destuffing is enabled, a 0 that arrives after exactly five consecutive 1s is discarded.
- R8: When destuffing is enabled, a 0 that arrives after six or more consecutive 1s is kept. The ones counter saturates at 6 and clears on any 0.
- R9: A read at address 3 returns the status and then clears it. After that, the interrupt goes high again.
- R10: If a byte completes in the same cycle as a status read, the status bit set by that byte stays set.
- R11: Reset clears the shift register, the bit count, the ones counter, the captured byte, the status bits and the control bits.
- R12: A bit presented while the valid strobe is low changes neither the shift register nor the bit count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dl_bit | input | 1 | Serial data link bit |
| dl_vld | input | 1 | Strobe marking dl_bit valid for one cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read at address 3 clears the status) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest situation to reach is a status read that falls in the same cycle as the eighth kept bit. The bench gets there by sending seven bits one at a time. It then drives the last bit and the status read on the same clock edge, and reads the status again afterwards. The destuffing boundary is also hard to reach from the ports. Each destuff scenario starts from reset, so the ones counter is known to be zero. The bench then places a zero directly after runs of exactly five ones and of six ones.

// File: rtl/dlc_pkg.sv
`timescale 1ns/1ps
package dlc_pkg;
  localparam int BYTE_W  = 8;
  localparam int RUN_LEN = 5;
  localparam int ONES_SAT = RUN_LEN + 1;
  localparam int ONES_W  = $clog2(ONES_SAT + 1);
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] A_DATA   = 2'd0;
  localparam logic [ADDR_W-1:0] A_MATCH0 = 2'd1;
  localparam logic [ADDR_W-1:0] A_MATCH1 = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT   = 2'd3;

  typedef struct packed {
    logic match_ie;
    logic full_ie;
    logic dstf_en;
  } ctrl_t;

  function automatic logic [ONES_W-1:0] ones_next(input logic [ONES_W-1:0] cur,
                                                  input logic b);
    if (!b) return '0;
    if (cur >= ONES_W'(ONES_SAT)) return ONES_W'(ONES_SAT);
    return cur + ONES_W'(1);
  endfunction

  function automatic logic byte_hits(input logic [BYTE_W-1:0] b,
                                     input logic [BYTE_W-1:0] m0,
                                     input logic [BYTE_W-1:0] m1);
    return (b == m0) || (b == m1);
  endfunction
endpackage

// File: rtl/dlc_destuff.sv
`timescale 1ns/1ps
module dlc_destuff
  import dlc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic vld,
  input  logic bit_in,
  output logic keep,
  output logic drop
);
  logic [ONES_W-1:0] ones_q;

  assign drop = vld && en && !bit_in && (ones_q == ONES_W'(RUN_LEN));
  assign keep = vld && !drop;

  always_ff @(posedge clk) begin
    if (!rst_n)   ones_q <= '0;
    else if (vld) ones_q <= ones_next(ones_q, bit_in);
  end

  p_ones_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= ONES_W'(ONES_SAT));
  p_no_drop_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !drop);
  p_drop_resets_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ones_q == '0);
  p_keep_needs_vld_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> !keep);
endmodule

// File: rtl/dlc_assembler.sv
`timescale 1ns/1ps
module dlc_assembler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         keep,
  input  logic         bit_in,
  output logic [W-1:0] cap_q,
  output logic [W-1:0] new_byte,
  output logic         byte_done
);
  localparam int IW = $clog2(W);
  logic [W-1:0]  sh_q;
  logic [IW-1:0] cnt_q;

  assign new_byte  = {bit_in, sh_q[W-1:1]};
  assign byte_done = keep && (cnt_q == IW'(W-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      cap_q <= '0;
    end else if (keep) begin
      sh_q  <= new_byte;
      cnt_q <= byte_done ? '0 : cnt_q + IW'(1);
      if (byte_done) cap_q <= new_byte;
    end
  end

  p_cap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(cap_q));
  p_count_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !keep |=> $stable(cnt_q) && $stable(sh_q));
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> cnt_q == '0);
endmodule

// File: rtl/dlc_regs.sv
`timescale 1ns/1ps
module dlc_regs
  import dlc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] cap,
  input  logic [BYTE_W-1:0] new_byte,
  input  logic              byte_done,
  output logic [BYTE_W-1:0] rdata,
  output ctrl_t             ctrl,
  output logic              irq_n
);
  logic [BYTE_W-1:0] m0_q, m1_q;
  logic st_full_q, st_match_q;
  logic stat_clr, hit;

  assign stat_clr = rd && (addr == A_STAT);
  assign hit      = byte_done && byte_hits(new_byte, m0_q, m1_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl       <= '0;
      m0_q       <= '0;
      m1_q       <= '0;
      st_full_q  <= 1'b0;
      st_match_q <= 1'b0;
    end else begin
      if (wr) begin
        case (addr)
          A_DATA:   ctrl <= ctrl_t'(wdata[2:0]);
          A_MATCH0: m0_q <= wdata;
          A_MATCH1: m1_q <= wdata;
          default:  ;
        endcase
      end
      if (byte_done)     st_full_q <= 1'b1;
      else if (stat_clr) st_full_q <= 1'b0;
      if (hit)           st_match_q <= 1'b1;
      else if (stat_clr) st_match_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_DATA:  rdata = cap;
      A_STAT:  rdata = {{(BYTE_W-2){1'b0}}, st_match_q, st_full_q};
      default: rdata = '0;
    endcase
  end

  assign irq_n = !((st_full_q && ctrl.full_ie) || (st_match_q && ctrl.match_ie));

  p_full_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> st_full_q);
  p_match_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> st_match_q);
  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !byte_done) |=> !st_full_q && !st_match_q);
  p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && byte_done) |=> st_full_q);
  p_no_spurious_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !st_match_q) |=> !st_match_q);
endmodule

// File: rtl/dlink_capture.sv
`timescale 1ns/1ps
module dlink_capture
  import dlc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dl_bit,
  input  logic              dl_vld,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq_n
);
  ctrl_t             ctrl;
  logic              bit_keep, bit_drop, byte_done;
  logic [BYTE_W-1:0] cap_byte, new_byte;

  dlc_destuff u_destuff (
    .clk(clk), .rst_n(rst_n), .en(ctrl.dstf_en), .vld(dl_vld),
    .bit_in(dl_bit), .keep(bit_keep), .drop(bit_drop)
  );

  dlc_assembler #(.W(BYTE_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .keep(bit_keep), .bit_in(dl_bit),
    .cap_q(cap_byte), .new_byte(new_byte), .byte_done(byte_done)
  );

  dlc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .cap(cap_byte), .new_byte(new_byte),
    .byte_done(byte_done), .rdata(reg_rdata), .ctrl(ctrl), .irq_n(irq_n)
  );

  p_drop_no_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_drop |-> !byte_done);
endmodule

// File: tb/dlink_capture_tb.sv
`timescale 1ns/1ps
module dlink_capture_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dl_bit = 1'b0, dl_vld = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic irq_n;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  dlink_capture dut_i (
    .clk(clk), .rst_n(rst_n), .dl_bit(dl_bit), .dl_vld(dl_vld),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; dl_vld = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); dl_vld = 1'b1; dl_bit = b;
    @(negedge clk); dl_vld = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic t_reset_r11();
    logic [7:0] d;
    wr_reg(2'd0, 8'h07);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    do_reset();
    rd_reg(2'd0, d); check("R11 data after reset", d, 8'h00);
    rd_reg(2'd3, d); check("R11 status after reset", d, 8'h00);
    check("R11 irq after reset", {7'd0, irq_n}, 8'h01);
    send_byte(8'h1F);
    rd_reg(2'd0, d); check("R11 count and destuff cleared", d, 8'h1F);
  endtask

  task automatic t_basic_r1_r2();
    logic [7:0] d;
    do_reset();
    send_byte(8'hA5);
    rd_reg(2'd0, d); check("R1 lsb first", d, 8'hA5);
    rd_reg(2'd3, d); check("R2 full set", d, 8'h01);
  endtask

  task automatic t_invalid_r12();
    logic [7:0] d;
    do_reset();
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    @(negedge clk); dl_bit = 1'b1;
    repeat (5) @(negedge clk);
    dl_bit = 1'b0;
    repeat (3) @(negedge clk);
    rd_reg(2'd3, d); check("R12 no byte yet", d, 8'h00);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    rd_reg(2'd0, d); check("R12 invalid bits ignored", d, 8'h3C);
  endtask

  task automatic t_overwrite_r3();
    logic [7:0] d;
    do_reset();
    send_byte(8'h11); send_byte(8'h22);
    rd_reg(2'd0, d); check("R3 overwritten", d, 8'h22);
  endtask

  task automatic t_match_r4();
    logic [7:0] d;
    do_reset();
    wr_reg(2'd1, 8'h7E); wr_reg(2'd2, 8'h81);
    send_byte(8'h81); rd_reg(2'd3, d); check("R4 match byte 1", d, 8'h03);
    send_byte(8'h7E); rd_reg(2'd3, d); check("R4 match byte 0", d, 8'h03);
    send_byte(8'h55); rd_reg(2'd3, d); check("R4 no match", d, 8'h01);
  endtask

  task automatic t_irq_r5_r9();
    logic [7:0] d;
    do_reset();
    wr_reg(2'd0, 8'h02);
    send_byte(8'h33);
    check("R5 irq on full", {7'd0, irq_n}, 8'h00);
    rd_reg(2'd3, d); check("R9 read returns status", d, 8'h01);
    check("R9 irq released", {7'd0, irq_n}, 8'h01);
    rd_reg(2'd3, d); check("R9 status cleared", d, 8'h00);
    wr_reg(2'd0, 8'h00);
    send_byte(8'h33);
    check("R5 masked full", {7'd0, irq_n}, 8'h01);
    rd_reg(2'd3, d);
    wr_reg(2'd1, 8'h44); wr_reg(2'd0, 8'h04);
    send_byte(8'h44);
    check("R5 irq on match", {7'd0, irq_n}, 8'h00);
    send_byte(8'h40);
    rd_reg(2'd3, d); check("R5 status before clear", d, 8'h03);
    check("R9 irq high after clear", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_nodestuff_r6();
    logic [7:0] d;
    do_reset();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    rd_reg(2'd0, d); check("R6 zero kept when off", d, 8'h5F);
  endtask

  task automatic t_destuff_r7();
    logic [7:0] d;
    do_reset();
    wr_reg(2'd0, 8'h01);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    send_bit(1'b0);
    rd_reg(2'd3, d); check("R7 five ones no byte yet", d, 8'h00);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    rd_reg(2'd0, d); check("R7 stuffed zero removed", d, 8'h9F);
  endtask

  task automatic t_six_r8();
    logic [7:0] d;
    do_reset();
    wr_reg(2'd0, 8'h01);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b1);
    rd_reg(2'd0, d); check("R8 zero after six ones kept", d, 8'hBF);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    send_bit(1'b0);
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    rd_reg(2'd0, d); check("R8 long run saturates", d, 8'h00);
  endtask

  task automatic t_collide_r10();
    logic [7:0] d;
    do_reset();
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    @(negedge clk); dl_vld = 1'b1; dl_bit = 1'b0; reg_rd = 1'b1; reg_addr = 2'd3;
    #1 d = reg_rdata; check("R10 read sees old status", d, 8'h00);
    @(negedge clk); dl_vld = 1'b0; reg_rd = 1'b0;
    rd_reg(2'd3, d); check("R10 event wins over clear", d, 8'h01);
    rd_reg(2'd0, d); check("R10 byte captured", d, 8'h7F);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_r11();
    t_basic_r1_r2();
    t_invalid_r12();
    t_overwrite_r3();
    t_match_r4();
    t_irq_r5_r9();
    t_nodestuff_r6();
    t_destuff_r7();
    t_six_r8();
    t_collide_r10();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule